// File: doc/BRIEF.md
# Skip-Group Operate Executor

This block carries out the skip-class operate instructions of a 12-bit accumulator machine that has a one-bit link. Each such instruction word selects any mix of three tests on the incoming accumulator and link: sign, zero and link set. A sense bit picks how the selected tests combine. With the sense bit clear, the block asks for a skip when any selected test is true. With it set, the combined result is inverted, so a skip needs every selected test to be false. When the sense bit is set and no test is selected, the skip is unconditional.

The same word can also clear the accumulator, OR the front-panel switch register into it, and request a halt. The tests always see the accumulator as it was before the clear. The clear is applied before the switch OR. The processor presents a word with `exec_i` high for one cycle. The new accumulator and the skip request appear registered on the next cycle. The halt flag stays high until `cont_i` is raised.

Top module: `skip_group_exec`

## Requirements
- R1: After reset `acc_o` is 0, `skip_o` is 0 and `halt_o` is 0.
- R2: An executed word is in this group only when `instr_i[11:8]` is 4'b1111 and `instr_i[0]` is 0. Any other executed word gives `acc_o` equal to `acc_i`, `skip_o` 0, and leaves `halt_o` unchanged.
- R3: When `instr_i[3]` (sense) is 0, `skip_o` is the OR of the selected tests: `instr_i[6]` tests `acc_i` MSB = 1, `instr_i[5]` tests `acc_i` = 0, and `instr_i[4]` tests `link_i` = 1. With sense 0, word 7540 octal skips exactly when the signed accumulator is ≤ 0.
- R4: When sense is 1, `skip_o` is the inverse of that OR. Word 7410 octal (no test selected) always skips. Word 7550 octal skips exactly when the signed accumulator is > 0.
- R5: The tests use `acc_i` as it was before any clear or switch OR in the same word.
- R6: `instr_i[7]` clears the accumulator result. Without `instr_i[2]`, the result is then 0.
- R7: `instr_i[2]` ORs `sw_i` into the accumulator after the clear. With both bits set, `acc_o` equals `sw_i`.
- R8: `instr_i[1]` sets `halt_o`. The flag holds until a cycle with `cont_i` high and no halting word being executed. A halting word in the same cycle as `cont_i` leaves it set.
- R9: Word 7400 octal (no action, sense 0) gives `acc_o` = `acc_i` and `skip_o` 0.
- R10: In a cycle with `exec_i` low, `acc_o` and `skip_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute the presented word this cycle |
| instr_i | input | 12 | Instruction word |
| acc_i | input | DATA_W | Accumulator before the instruction |
| link_i | input | 1 | Link bit |
| sw_i | input | DATA_W | Front-panel switch register |
| cont_i | input | 1 | Continue: clears the halt flag |
| acc_o | output | DATA_W | Accumulator after the instruction |
| skip_o | output | 1 | Skip request of the last executed word |
| halt_o | output | 1 | Halt flag |

## Verification
The accumulator result, the skip request and the halt flag each pass through one register. All three are due on the first rising edge after the cycle in which `exec_i` is high. The bench drives inputs on the falling edge. It lets one rising edge pass and compares at the next falling edge against a model held in bench functions. The halt flag is tracked across operations, so set, hold and continue are each checked on the cycle they are due.

// File: rtl/skip_group_pkg.sv
package skip_group_pkg;
  localparam int unsigned INSTR_W = 12;

  typedef struct packed {
    logic in_group;
    logic clr_acc;
    logic t_neg;
    logic t_zero;
    logic t_link;
    logic invert;
    logic or_sw;
    logic halt;
  } grp_op_t;
endpackage

// File: rtl/skip_group_decode.sv
module skip_group_decode
  import skip_group_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output grp_op_t            op_o
);
  logic hit;
  assign hit = (instr_i[11:8] == 4'b1111) && !instr_i[0];

  always_comb begin
    op_o          = '0;
    op_o.in_group = hit;
    if (hit) begin
      op_o.clr_acc = instr_i[7];
      op_o.t_neg   = instr_i[6];
      op_o.t_zero  = instr_i[5];
      op_o.t_link  = instr_i[4];
      op_o.invert  = instr_i[3];
      op_o.or_sw   = instr_i[2];
      op_o.halt    = instr_i[1];
    end
  end
endmodule

// File: rtl/skip_group_cond.sv
module skip_group_cond
  import skip_group_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  grp_op_t           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  output logic              skip_o
);
  localparam int unsigned SIGN_B = DATA_W - 1;

  logic any_hit;
  // tests see the accumulator before any clear
  assign any_hit = (op_i.t_neg  && acc_i[SIGN_B])
                 | (op_i.t_zero && (acc_i == '0))
                 | (op_i.t_link && link_i);

  assign skip_o = op_i.in_group && (any_hit ^ op_i.invert);
endmodule

// File: rtl/skip_group_acc.sv
module skip_group_acc
  import skip_group_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  grp_op_t           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] cleared;
  assign cleared = op_i.clr_acc ? '0 : acc_i;
  assign acc_o   = op_i.or_sw ? (cleared | sw_i) : cleared;
endmodule

// File: rtl/skip_group_exec.sv
module skip_group_exec
  import skip_group_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic               link_i,
  input  logic [DATA_W-1:0]  sw_i,
  input  logic               cont_i,
  output logic [DATA_W-1:0]  acc_o,
  output logic               skip_o,
  output logic               halt_o
);
  grp_op_t           op;
  logic              skip_d;
  logic [DATA_W-1:0] acc_d;

  skip_group_decode u_dec (
    .instr_i (instr_i),
    .op_o    (op)
  );

  skip_group_cond #(.DATA_W(DATA_W)) u_cond (
    .op_i   (op),
    .acc_i  (acc_i),
    .link_i (link_i),
    .skip_o (skip_d)
  );

  skip_group_acc #(.DATA_W(DATA_W)) u_acc (
    .op_i  (op),
    .acc_i (acc_i),
    .sw_i  (sw_i),
    .acc_o (acc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      skip_o <= 1'b0;
    end else if (exec_i) begin
      acc_o  <= acc_d;
      skip_o <= skip_d;
    end
  end

  // new halt request wins over continue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                halt_o <= 1'b0;
    else if (exec_i && op.halt) halt_o <= 1'b1;
    else if (cont_i)            halt_o <= 1'b0;
  end
endmodule

// File: rtl/skip_group_exec_chk.sv
module skip_group_exec_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [11:0]       instr_i,
  input logic [DATA_W-1:0] acc_i,
  input logic              cont_i,
  input logic [DATA_W-1:0] sw_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              skip_o,
  input logic              halt_o
);
  logic grp;
  assign grp = (instr_i[11:8] == 4'b1111) && !instr_i[0];

  // R2
  foreign_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !grp) |=> (acc_o == $past(acc_i)) && !skip_o);

  // R4
  uncond_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && grp && instr_i[3] && (instr_i[6:4] == 3'b000)) |=> skip_o);

  // R6
  clear_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && grp && instr_i[7] && !instr_i[2]) |=> (acc_o == '0));

  // R7
  load_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && grp && instr_i[7] && instr_i[2]) |=> (acc_o == $past(sw_i)));

  // R8
  halt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && grp && instr_i[1]) |=> halt_o);

  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !cont_i) |=> halt_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(acc_o) && $stable(skip_o));
endmodule

bind skip_group_exec skip_group_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .exec_i  (exec_i),
  .instr_i (instr_i),
  .acc_i   (acc_i),
  .cont_i  (cont_i),
  .sw_i    (sw_i),
  .acc_o   (acc_o),
  .skip_o  (skip_o),
  .halt_o  (halt_o)
);

// File: tb/skip_group_exec_test.sv
module skip_group_exec_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         exec = 1'b0;
  logic [11:0]  instr = '0;
  logic [W-1:0] acc = '0;
  logic         link = 1'b0;
  logic [W-1:0] sw = '0;
  logic         cont = 1'b0;
  logic [W-1:0] acc_q;
  logic         skip_q;
  logic         halt_q;

  int checks = 0;
  int errors = 0;
  logic         m_halt = 1'b0;
  logic [W-1:0] m_acc = '0;
  logic         m_skip = 1'b0;

  always #2.5 clk = ~clk;

  skip_group_exec #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .instr_i(instr),
    .acc_i(acc), .link_i(link), .sw_i(sw), .cont_i(cont),
    .acc_o(acc_q), .skip_o(skip_q), .halt_o(halt_q)
  );

  function automatic logic is_grp(input logic [11:0] w);
    return (w[11:8] == 4'b1111) && (w[0] == 1'b0);
  endfunction

  function automatic logic exp_skip(input logic [11:0] w, input logic [W-1:0] a, input logic l);
    logic c;
    if (!is_grp(w)) return 1'b0;
    c = (w[6] && a[W-1]) || (w[5] && a == 0) || (w[4] && l);
    return w[3] ? !c : c;
  endfunction

  function automatic logic [W-1:0] exp_acc(input logic [11:0] w, input logic [W-1:0] a, input logic [W-1:0] s);
    logic [W-1:0] r;
    if (!is_grp(w)) return a;
    r = w[7] ? '0 : a;
    if (w[2]) r = r | s;
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [11:0] w, input logic [W-1:0] a,
                        input logic l, input logic [W-1:0] s, input logic c);
    instr = w; acc = a; link = l; sw = s; cont = c; exec = 1'b1;
    m_acc  = exp_acc(w, a, s);
    m_skip = exp_skip(w, a, l);
    if (is_grp(w) && w[1]) m_halt = 1'b1;
    else if (c)            m_halt = 1'b0;
    @(posedge clk);
    @(negedge clk);
    exec = 1'b0; cont = 1'b0;
    check({req, " acc"},  acc_q, m_acc);
    check({req, " skip"}, W'(skip_q), W'(m_skip));
    check({req, " halt"}, W'(halt_q), W'(m_halt));
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] w;
    void'($urandom(32'd1234));
    #12 @(negedge clk);
    // R1
    check("R1 acc", acc_q, '0);
    check("R1 skip", W'(skip_q), '0);
    check("R1 halt", W'(halt_q), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 no-op
    run_op("R9", 12'o7400, 12'o1234, 1'b1, 12'o7777, 1'b0);
    // R3 7540 skips on acc <= 0
    run_op("R3 neg", 12'o7540, 12'o4000, 1'b0, '0, 1'b0);
    run_op("R3 zero", 12'o7540, 12'o0000, 1'b0, '0, 1'b0);
    run_op("R3 pos", 12'o7540, 12'o0001, 1'b0, '0, 1'b0);
    run_op("R3 link", 12'o7420, 12'o0005, 1'b1, '0, 1'b0);
    // R4 unconditional and acc > 0
    run_op("R4 skp", 12'o7410, 12'o0000, 1'b1, '0, 1'b0);
    run_op("R4 pos", 12'o7550, 12'o0001, 1'b0, '0, 1'b0);
    run_op("R4 zero", 12'o7550, 12'o0000, 1'b0, '0, 1'b0);
    run_op("R4 neg", 12'o7550, 12'o7777, 1'b0, '0, 1'b0);
    // R5 test sees pre-clear value
    run_op("R5", 12'o7640, 12'o0007, 1'b0, '0, 1'b0);
    run_op("R5 sna", 12'o7650, 12'o0007, 1'b0, '0, 1'b0);
    // R6 clear
    run_op("R6", 12'o7600, 12'o5555, 1'b0, 12'o1111, 1'b0);
    // R7 switch OR and load
    run_op("R7 or", 12'o7404, 12'o0070, 1'b0, 12'o0007, 1'b0);
    run_op("R7 load", 12'o7604, 12'o7070, 1'b0, 12'o0123, 1'b0);
    // R2 foreign words
    run_op("R2 g1", 12'o7200, 12'o3333, 1'b1, '0, 1'b0);
    run_op("R2 g3", 12'o7603, 12'o3333, 1'b1, '0, 1'b0);
    // R8 halt set, hold, continue, priority
    run_op("R8 set", 12'o7402, 12'o0001, 1'b0, '0, 1'b0);
    run_op("R8 hold", 12'o7400, 12'o0001, 1'b0, '0, 1'b0);
    run_op("R8 prio", 12'o7402, 12'o0001, 1'b0, '0, 1'b1);
    run_op("R8 cont", 12'o7400, 12'o0001, 1'b0, '0, 1'b1);
    // R10 idle holds outputs
    acc = 12'o7777; instr = 12'o7600; sw = 12'o7777;
    repeat (3) @(negedge clk);
    check("R10 acc", acc_q, m_acc);
    check("R10 skip", W'(skip_q), W'(m_skip));

    // R3 R4 R6 R7 random group words mixed with others
    for (int i = 0; i < 400; i++) begin
      w = ($urandom_range(0, 3) != 0) ? {4'b1111, 7'($urandom), 1'b0} : 12'($urandom);
      run_op("RND", w, W'($urandom), 1'($urandom), W'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule